// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block conditions the second source operand of an integer datapath before it reaches the arithmetic unit. It takes an operand, a shift kind, a shift distance and the current carry flag. It returns the shifted or rotated operand together with the carry that the shift produces. That carry is the last bit to leave the operand, so a flag-setting logical operation can take its carry straight from this block.

Five kinds are supported: logical left, logical right, arithmetic right, rotate right, and a one-place rotate right through the carry flag. The core is a logarithmic chain of right-shifting stages. A one-bit guard travels alongside the data and collects the carry. Left shifts reuse the same chain by reversing the bit order on the way in and on the way out.

By default a single output register closes the path, so results appear one clock after the inputs. A parameter removes that register for a purely combinational build.

Top module: `bshift_top`

## Requirements
- R1: Kind code 0 (logical left) by n places gives the operand times 2^n modulo 2^32, with zeros entering at bit 0; by 4 places this multiplies by 16.
- R2: Kind code 1 (logical right) by n places fills the top n bits with zeros.
- R3: Kind code 2 (arithmetic right) by n places fills the vacated top positions with copies of operand bit 31.
- R4: Kind code 3 (rotate right) by n places moves operand bits [n-1:0] to the top of the result and loses no bit.
- R5: Kind code 4 (rotate right through carry) ignores the distance. Result bit 31 takes the incoming carry, bits 30..0 take operand bits 31..1, and operand bit 0 becomes the carry-out.
- R6: For kind codes 0 to 3, a distance of 0 returns the operand unchanged, and the carry-out equals the incoming carry.
- R7: For a nonzero distance n, the carry-out is the last bit shifted or rotated out: operand bit 32-n for a left shift, and operand bit n-1 for the right shifts and the rotate.
- R8: Kind codes 5 to 7 pass the operand through unchanged, and the carry-out equals the incoming carry.
- R9: With the output stage enabled (default), the result and carry-out reflect the inputs sampled at the previous rising clock edge.
- R10: While rst_n is low, the result and carry-out are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| sh_kind | input | 3 | Shift kind code (0..4 defined, 5..7 pass-through) |
| sh_amt | input | 5 | Shift distance, 0 to 31 |
| carry_in | input | 1 | Current carry flag |
| opnd_in | input | 32 | Operand to be shifted |
| res_out | output | 32 | Shifted or rotated operand |
| carry_out | output | 1 | Carry produced by the shift |

## Verification
The temporal checks assume that every input is a settled, known value at each rising edge. They compare each output with the inputs of the previous edge only after one full post-reset cycle has passed. The stimulus therefore changes the kind, distance, carry and operand on falling edges only. It releases reset on a falling edge as well, and it never leaves an input undriven. The checks also assume that a rotate conserves the operand's population count and that zero-distance shifts are identities. The stimulus sweeps every distance for every kind code, including the undefined ones, so each of these conditions is exercised.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

   typedef enum logic [2:0] {
      SK_LSL = 3'd0,
      SK_LSR = 3'd1,
      SK_ASR = 3'd2,
      SK_ROR = 3'd3,
      SK_RRX = 3'd4
   } shift_kind_e;

   localparam int unsigned KIND_W = 3;

endpackage

// File: rtl/bshift_rev.sv
module bshift_rev #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign d_out[i] = d_in[WIDTH-1-i];
   end

endmodule

// File: rtl/bshift_stage.sv
module bshift_stage #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned STEP  = 1
) (
   input  logic             en,
   input  logic             rot,
   input  logic             fill,
   input  logic [WIDTH-1:0] d_in,
   input  logic             g_in,
   output logic [WIDTH-1:0] d_out,
   output logic             g_out
);

   if (STEP < 1 || STEP >= WIDTH) begin : g_bad_step
      $error("bshift_stage: STEP must lie in 1..WIDTH-1");
   end

   logic [WIDTH-1:0] rot_val;
   logic [WIDTH-1:0] fill_val;

   assign rot_val  = {d_in[STEP-1:0], d_in[WIDTH-1:STEP]};
   assign fill_val = {{STEP{fill}}, d_in[WIDTH-1:STEP]};

   always_comb begin
      if (en) begin
         d_out = rot ? rot_val : fill_val;
         g_out = d_in[STEP-1];
      end else begin
         d_out = d_in;
         g_out = g_in;
      end
   end

endmodule

// File: rtl/bshift_top.sv
module bshift_top
   import bshift_pkg::*;
#(
   parameter int unsigned WIDTH     = 32,
   parameter int unsigned AMT_W     = $clog2(WIDTH),
   parameter bit          OUT_STAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [KIND_W-1:0] sh_kind,
   input  logic [AMT_W-1:0]  sh_amt,
   input  logic              carry_in,
   input  logic [WIDTH-1:0]  opnd_in,
   output logic [WIDTH-1:0]  res_out,
   output logic              carry_out
);

   localparam int unsigned NSTAGE = AMT_W;

   if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("bshift_top: WIDTH must be a power of two, at least 2");
   end
   if ((1 << AMT_W) != WIDTH) begin : g_bad_amt
      $error("bshift_top: AMT_W must equal log2(WIDTH)");
   end

   shift_kind_e kind;
   logic        is_left;
   logic        is_rot;
   logic        fill_bit;

   assign kind     = shift_kind_e'(sh_kind);
   assign is_left  = (kind == SK_LSL);
   assign is_rot   = (kind == SK_ROR);
   assign fill_bit = (kind == SK_ASR) & opnd_in[WIDTH-1];

   logic [WIDTH-1:0] opnd_rev;
   logic [WIDTH-1:0] core_rev;
   logic [WIDTH-1:0] core_post;

   bshift_rev #(.WIDTH(WIDTH)) u_rev_in (
      .d_in  (opnd_in),
      .d_out (opnd_rev)
   );

   logic [WIDTH-1:0] dch [NSTAGE+1];
   logic             gch [NSTAGE+1];

   assign dch[0] = is_left ? opnd_rev : opnd_in;
   assign gch[0] = carry_in;

   for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
      bshift_stage #(
         .WIDTH (WIDTH),
         .STEP  (1 << k)
      ) u_stage (
         .en    (sh_amt[k]),
         .rot   (is_rot),
         .fill  (fill_bit),
         .d_in  (dch[k]),
         .g_in  (gch[k]),
         .d_out (dch[k+1]),
         .g_out (gch[k+1])
      );
   end

   bshift_rev #(.WIDTH(WIDTH)) u_rev_out (
      .d_in  (dch[NSTAGE]),
      .d_out (core_rev)
   );

   assign core_post = is_left ? core_rev : dch[NSTAGE];

   logic [WIDTH-1:0] res_nxt;
   logic             c_nxt;

   always_comb begin
      unique case (kind)
         SK_LSL, SK_LSR, SK_ASR, SK_ROR: begin
            res_nxt = core_post;
            c_nxt   = gch[NSTAGE];
         end
         SK_RRX: begin
            res_nxt = {carry_in, opnd_in[WIDTH-1:1]};
            c_nxt   = opnd_in[0];
         end
         default: begin
            res_nxt = opnd_in;
            c_nxt   = carry_in;
         end
      endcase
   end

   if (OUT_STAGE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_out   <= '0;
            carry_out <= 1'b0;
         end else begin
            res_out   <= res_nxt;
            carry_out <= c_nxt;
         end
      end
   end else begin : g_comb
      assign res_out   = res_nxt;
      assign carry_out = c_nxt;
   end

endmodule

// File: rtl/bshift_chk.sv
module bshift_chk #(
   parameter int unsigned WIDTH     = 32,
   parameter int unsigned AMT_W     = 5,
   parameter bit          OUT_STAGE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       sh_kind,
   input logic [AMT_W-1:0] sh_amt,
   input logic             carry_in,
   input logic [WIDTH-1:0] opnd_in,
   input logic [WIDTH-1:0] res_out,
   input logic             carry_out
);

   logic primed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   if (OUT_STAGE) begin : g_props
      assert_lsl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(sh_kind == 3'd0 && sh_amt != '0) |-> res_out[0] == 1'b0);

      assert_lsr_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(sh_kind == 3'd1 && sh_amt != '0) |-> res_out[WIDTH-1] == 1'b0);

      assert_asr_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(sh_kind == 3'd2) |-> res_out[WIDTH-1] == $past(opnd_in[WIDTH-1]));

      assert_ror_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(sh_kind == 3'd3) |-> $countones(res_out) == $countones($past(opnd_in)));

      assert_rrx_flow_R5: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(sh_kind == 3'd4) |->
            (res_out[WIDTH-1] == $past(carry_in)) && (carry_out == $past(opnd_in[0])));

      assert_zero_dist_R6: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(sh_kind <= 3'd3 && sh_amt == '0) |->
            (res_out == $past(opnd_in)) && (carry_out == $past(carry_in)));

      assert_ror_one_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(sh_kind == 3'd3 && sh_amt == 1) |-> carry_out == $past(opnd_in[0]));

      assert_undef_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(sh_kind > 3'd4) |->
            (res_out == $past(opnd_in)) && (carry_out == $past(carry_in)));
   end

endmodule

bind bshift_top bshift_chk #(
   .WIDTH     (WIDTH),
   .AMT_W     (AMT_W),
   .OUT_STAGE (OUT_STAGE)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .sh_kind   (sh_kind),
   .sh_amt    (sh_amt),
   .carry_in  (carry_in),
   .opnd_in   (opnd_in),
   .res_out   (res_out),
   .carry_out (carry_out)
);

// File: tb/bshift_top_tb_top.sv
`timescale 1ns/1ps
module bshift_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  sh_kind = '0;
   logic [4:0]  sh_amt = '0;
   logic        carry_in = 1'b0;
   logic [31:0] opnd_in = '0;
   logic [31:0] res_out;
   logic        carry_out;

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bshift_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sh_kind   (sh_kind),
      .sh_amt    (sh_amt),
      .carry_in  (carry_in),
      .opnd_in   (opnd_in),
      .res_out   (res_out),
      .carry_out (carry_out)
   );

   // fields: kind[73:71] amt[70:66] cin[65] opnd[64:33] res[32:1] cout[0]
   localparam logic [73:0] VEC [14] = '{
      {3'd0, 5'd4,  1'b0, 32'h0000_0003, 32'h0000_0030, 1'b0},
      {3'd0, 5'd4,  1'b0, 32'hF000_0001, 32'h0000_0010, 1'b1},
      {3'd0, 5'd31, 1'b0, 32'h0000_0003, 32'h8000_0000, 1'b1},
      {3'd1, 5'd1,  1'b0, 32'h0000_0003, 32'h0000_0001, 1'b1},
      {3'd1, 5'd31, 1'b1, 32'h8000_0000, 32'h0000_0001, 1'b0},
      {3'd2, 5'd4,  1'b1, 32'h8000_0010, 32'hF800_0001, 1'b0},
      {3'd2, 5'd31, 1'b0, 32'hC000_0000, 32'hFFFF_FFFF, 1'b1},
      {3'd3, 5'd8,  1'b1, 32'h1234_5678, 32'h7812_3456, 1'b0},
      {3'd3, 5'd1,  1'b0, 32'h0000_0001, 32'h8000_0000, 1'b1},
      {3'd4, 5'd0,  1'b1, 32'h0000_0002, 32'h8000_0001, 1'b0},
      {3'd4, 5'd7,  1'b0, 32'h0000_0001, 32'h0000_0000, 1'b1},
      {3'd0, 5'd0,  1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1},
      {3'd3, 5'd0,  1'b0, 32'h8000_0001, 32'h8000_0001, 1'b0},
      {3'd7, 5'd3,  1'b1, 32'h0000_0055, 32'h0000_0055, 1'b1}
   };

   function automatic string tag_of(input logic [2:0] k, input logic [4:0] a);
      if (a == 0 && k <= 3'd3) return "R6";
      case (k)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         default: return "R8";
      endcase
   endfunction

   // bit-serial reference, one place per iteration
   function automatic logic [32:0] model(input logic [2:0] k, input logic [4:0] a,
                                         input logic ci, input logic [31:0] v);
      logic [31:0] w = v;
      logic        c = ci;
      case (k)
         3'd0: for (int i = 0; i < a; i++) begin c = w[31]; w = {w[30:0], 1'b0}; end
         3'd1: for (int i = 0; i < a; i++) begin c = w[0];  w = {1'b0, w[31:1]}; end
         3'd2: for (int i = 0; i < a; i++) begin c = w[0];  w = {w[31], w[31:1]}; end
         3'd3: for (int i = 0; i < a; i++) begin c = w[0];  w = {w[0], w[31:1]}; end
         3'd4: begin c = v[0]; w = {ci, v[31:1]}; end
         default: ;
      endcase
      return {c, w};
   endfunction

   task automatic check(input string tag, input logic [31:0] er, input logic ec);
      total++;
      if (res_out !== er) begin
         bad++;
         $display("FAIL %s result: actual=%h expected=%h", tag, res_out, er);
      end
      total++;
      if (carry_out !== ec) begin
         bad++;
         $display("FAIL %s carry (R7): actual=%b expected=%b", tag, carry_out, ec);
      end
   endtask

   task automatic drive(input logic [2:0] k, input logic [4:0] a,
                        input logic ci, input logic [31:0] v);
      sh_kind = k; sh_amt = a; carry_in = ci; opnd_in = v;
   endtask

   // drive on a falling edge, check on the next falling edge (one register, R9)
   task automatic run_one(input logic [2:0] k, input logic [4:0] a, input logic ci,
                          input logic [31:0] v, input logic [31:0] er, input logic ec);
      @(negedge clk);
      drive(k, a, ci, v);
      @(negedge clk);
      check(tag_of(k, a), er, ec);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [32:0] m;
      logic [31:0] prev_r;
      logic        prev_c;

      // R10: outputs held at zero under reset even with live inputs
      drive(3'd4, 5'd3, 1'b1, 32'hFFFF_FFFF);
      repeat (3) @(negedge clk);
      check("R10", 32'h0, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < 14; i++) begin
         run_one(VEC[i][73:71], VEC[i][70:66], VEC[i][65], VEC[i][64:33],
                 VEC[i][32:1], VEC[i][0]);
      end

      // sweep of every kind and distance against the serial reference
      for (int k = 0; k < 8; k++) begin
         for (int a = 0; a < 32; a++) begin
            for (int p = 0; p < 2; p++) begin
               logic [31:0] v = (p == 0) ? 32'hA5C3_0F96 : 32'h7E01_8B34;
               logic        ci = logic'((a + p) & 1);
               m = model(3'(k), 5'(a), ci, v);
               run_one(3'(k), 5'(a), ci, v, m[31:0], m[32]);
            end
         end
      end

      // R9: a new input does not reach the outputs before the next rising edge
      run_one(3'd0, 5'd4, 1'b0, 32'h0000_0003, 32'h0000_0030, 1'b0);
      prev_r = res_out;
      prev_c = carry_out;
      @(negedge clk);
      drive(3'd1, 5'd1, 1'b0, 32'hFFFF_FFFF);
      #1;
      check("R9", prev_r, prev_c);
      @(negedge clk);
      check("R9", 32'h7FFF_FFFF, 1'b1);

      // R10: asynchronous reset clears the outputs mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R10", 32'h0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      run_one(3'd2, 5'd1, 1'b0, 32'h8000_0000, 32'hC000_0000, 1'b0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule